// File: doc/BRIEF.md
# Motor Driver Chain Datagram Sequencer

This block assembles one serial datagram for a daisy chain of stepper motor drivers. It holds a small configuration store of 6-bit words. A host writes the store one word at a time. Each word combines a next-motor flag with a 5-bit code. The code picks one line from a 32-bit signal bus supplied by the micro-step logic.

On a start pulse the sequencer reads the store from word 0 upward, one word per clock. For each word it emits the selected signal bit on a serial output, together with a valid strobe and the index of the motor that the bit belongs to. Every flagged word closes one motor's section. The flagged word read while the motor counter equals the programmed last-driver index is the final bit of the datagram.

If the store runs out before that happens, the transfer still ends and an error flag is raised. A one-cycle done pulse follows the final bit, and the motor counter is back at zero for the next datagram.

Top module: `chain_datagram_seq`

## Requirements
- R1: While reset is applied and after it is released, busy, ser_vld, done and proto_err are all 0 until the first start.
- R2: A host write stores cfg_wdata at word index cfg_widx. Index bit 0 picks the even word (0) or the odd word (1) of address cfg_widx[5:1]. Data bit 5 is the next-motor flag and bits 4:0 are the signal code.
- R3: A start seen while idle makes busy rise on the next cycle. The words are then read from index 0 in ascending order, and each emits one bit on consecutive cycles with no gap. The first ser_vld is high two cycles after the start was sampled.
- R4: Each emitted ser_bit equals sig_bus[code] of the word being read, where code is that word's bits 4:0.
- R5: ser_motor gives the number of flagged words that came before the current word in this datagram. It never exceeds last_drv.
- R6: A word whose flag is 1 and whose ser_motor equals last_drv emits the final bit. done is high for exactly one cycle, the cycle right after the final ser_vld, and busy is low from that same cycle.
- R7: A start that arrives while busy is high is ignored. The datagram length and content stay unchanged, and no further transfer follows.
- R8: If word 63 is read without ending the datagram, its bit is the final one. proto_err is then high from the cycle of that bit until the next accepted start. A datagram that ends normally leaves proto_err at 0.
- R9: After any datagram ends, the motor counter is 0, so the first bit of the next datagram carries ser_motor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Host write strobe for the configuration store |
| cfg_widx | input | 6 | Word index for the host write |
| cfg_wdata | input | 6 | Word to store: flag in bit 5, code in bits 4:0 |
| last_drv | input | 2 | Index of the last driver in the chain |
| sig_bus | input | 32 | Signal lines offered by the micro-step logic |
| start | input | 1 | Start pulse for one datagram |
| busy | output | 1 | A transfer is in progress |
| ser_bit | output | 1 | Serial datagram bit |
| ser_vld | output | 1 | ser_bit is valid this cycle |
| ser_motor | output | 2 | Motor index of the current bit |
| done | output | 1 | One-cycle pulse after the final bit |
| proto_err | output | 1 | The last datagram ran out of words before its last driver |

## Verification
The bench builds the block with its default parameters: 32 addresses of two words each, a 32-line signal bus and a 2-bit motor counter. This small setting lets the bench fill the whole 64-word store and walk every last-driver value from 0 to 3. It covers several flag and code patterns, a store where every word is flagged, and one with no flags at all, which forces a full walk that ends in the overrun error. Each datagram is predicted in the bench bit by bit from the words that were written and from the signal bus.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/chain_rst_sync.sv
module chain_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/chain_cfg_mem.sv
module chain_cfg_mem #(
  parameter int N_WORDS = 64,
  parameter int WORD_W  = 6,
  localparam int IDX_W  = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] store_q [N_WORDS];

  // storage array: written only under the host enable, no reset
  always_ff @(posedge clk) begin
    if (we) store_q[widx] <= wdata;
  end

  assign rdata = store_q[ridx];
endmodule

// File: rtl/chain_sig_sel.sv
module chain_sig_sel #(
  parameter int CODE_W = 5,
  localparam int N_SIG = 1 << CODE_W
) (
  input  logic [N_SIG-1:0]  sig_bus,
  input  logic [CODE_W-1:0] code,
  output logic              sel_bit
);
  assign sel_bit = sig_bus[code];
endmodule

// File: rtl/chain_seq_ctrl.sv
module chain_seq_ctrl
  import chain_seq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             start,
  input  logic             word_flag,
  input  logic             sel_bit,
  input  logic [CNT_W-1:0] last_drv,
  output logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic             ser_bit,
  output logic             ser_vld,
  output logic [CNT_W-1:0] ser_motor,
  output logic             done,
  output logic             proto_err
);
  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             vld_q, vld_d, bit_q, bit_d, done_q, done_d, err_q, err_d;
  logic [CNT_W-1:0] mot_q, mot_d;
  logic             bit_en, is_final;

  assign is_final = word_flag && (cnt_q == last_drv);
  assign bit_en   = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    vld_d   = 1'b0;
    done_d  = 1'b0;
    bit_d   = bit_q;
    mot_d   = mot_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          idx_d   = '0;
          cnt_d   = '0;
          err_d   = 1'b0;
        end
      end
      ST_RUN: begin
        vld_d = 1'b1;
        bit_d = sel_bit;
        mot_d = cnt_q;
        if (is_final) begin
          state_d = ST_FLUSH;
          cnt_d   = '0;
        end else if (idx_q == IDX_LAST) begin
          state_d = ST_FLUSH;
          cnt_d   = '0;
          err_d   = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          cnt_d = cnt_q + CNT_W'(word_flag);
        end
      end
      ST_FLUSH: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // payload registers: loaded only while words are being read
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bit_q <= 1'b0;
      mot_q <= '0;
    end else if (bit_en) begin
      bit_q <= bit_d;
      mot_q <= mot_d;
    end
  end

  assign rd_idx    = idx_q;
  assign busy      = (state_q != ST_IDLE);
  assign ser_bit   = bit_q;
  assign ser_vld   = vld_q;
  assign ser_motor = mot_q;
  assign done      = done_q;
  assign proto_err = err_q;
endmodule

// File: rtl/chain_datagram_seq.sv
module chain_datagram_seq #(
  parameter int N_ADDR = 32,
  parameter int CODE_W = 5,
  parameter int CNT_W  = 2,
  localparam int N_WORDS = 2 * N_ADDR,
  localparam int WORD_W  = CODE_W + 1,
  localparam int IDX_W   = $clog2(N_WORDS),
  localparam int N_SIG   = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_widx,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic [CNT_W-1:0]  last_drv,
  input  logic [N_SIG-1:0]  sig_bus,
  input  logic              start,
  output logic              busy,
  output logic              ser_bit,
  output logic              ser_vld,
  output logic [CNT_W-1:0]  ser_motor,
  output logic              done,
  output logic              proto_err
);
  logic              srst_n;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic              sel_bit;

  chain_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  chain_cfg_mem #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_mem (
    .clk   (clk),
    .we    (cfg_we),
    .widx  (cfg_widx),
    .wdata (cfg_wdata),
    .ridx  (rd_idx),
    .rdata (rd_word)
  );

  chain_sig_sel #(.CODE_W(CODE_W)) u_sel (
    .sig_bus (sig_bus),
    .code    (rd_word[CODE_W-1:0]),
    .sel_bit (sel_bit)
  );

  chain_seq_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .srst_n    (srst_n),
    .start     (start),
    .word_flag (rd_word[WORD_W-1]),
    .sel_bit   (sel_bit),
    .last_drv  (last_drv),
    .rd_idx    (rd_idx),
    .busy      (busy),
    .ser_bit   (ser_bit),
    .ser_vld   (ser_vld),
    .ser_motor (ser_motor),
    .done      (done),
    .proto_err (proto_err)
  );
endmodule

// File: rtl/chain_datagram_seq_chk.sv
module chain_datagram_seq_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] last_drv,
  input logic             busy,
  input logic             ser_vld,
  input logic [CNT_W-1:0] ser_motor,
  input logic             done,
  input logic             proto_err
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ser_vld) && !busy);

  // R3
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3
  vld_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_vld |-> busy);

  // R5
  motor_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_vld && $stable(last_drv)) |-> (ser_motor <= last_drv));

  // R8
  err_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |=> done);
endmodule

bind chain_datagram_seq chain_datagram_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/chain_datagram_seq_bench.sv
module chain_datagram_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_widx = '0;
  logic [5:0]  cfg_wdata = '0;
  logic [1:0]  last_drv = '0;
  logic [31:0] sig_bus = '0;
  logic        start = 1'b0;
  logic        busy, ser_bit, ser_vld, done, proto_err;
  logic [1:0]  ser_motor;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [5:0] cfg_img [64];
  logic       exp_bit [64];
  logic [1:0] exp_mot [64];
  int         exp_len;
  logic       exp_err;

  chain_datagram_seq u_chain_datagram_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
    .cfg_wdata(cfg_wdata), .last_drv(last_drv), .sig_bus(sig_bus),
    .start(start), .busy(busy), .ser_bit(ser_bit), .ser_vld(ser_vld),
    .ser_motor(ser_motor), .done(done), .proto_err(proto_err)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2: index bit 0 chooses the even or odd word, bit 5 is the flag
  task automatic load_cfg(input int seed, input int mode);
    for (int i = 0; i < 64; i++) begin
      logic fl;
      logic [4:0] cd;
      cd = 5'((i * 3 + seed * 7 + i / 5) % 32);
      if (mode == 1)      fl = 1'b1;
      else if (mode == 2) fl = 1'b0;
      else                fl = ((i * 7 + seed) % 5) == 0;
      cfg_img[i] = {fl, cd};
      @(negedge clk);
      cfg_we = 1'b1; cfg_widx = 6'(i); cfg_wdata = {fl, cd};
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic build_exp(input logic [1:0] ld);
    logic [1:0] cnt;
    bit fin;
    cnt = '0; fin = 1'b0; exp_len = 0; exp_err = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (!fin) begin
        exp_bit[exp_len] = sig_bus[cfg_img[i][4:0]];
        exp_mot[exp_len] = cnt;
        exp_len++;
        if (cfg_img[i][5]) begin
          if (cnt == ld) fin = 1'b1;
          else cnt = cnt + 2'd1;
        end
        if (i == 63 && !fin) begin
          fin = 1'b1;
          exp_err = 1'b1;
        end
      end
    end
  endtask

  task automatic run_dgram(input logic [1:0] ld, input bit poke);
    int got, first_c, last_c, c;
    bit seen_done, prev_vld;
    last_drv = ld;
    build_exp(ld);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    got = 0; first_c = -1; last_c = -1; c = 1; seen_done = 0; prev_vld = 0;
    while (!seen_done && c < 200) begin
      @(negedge clk);
      c++;
      if (poke && got == 3) start = 1'b1;
      else start = 1'b0;
      if (ser_vld) begin
        if (first_c < 0) first_c = c;
        last_c = c;
        if (got < 64) begin
          if (ser_bit !== exp_bit[got])
            chk(0, "R4 bit value", int'(ser_bit), int'(exp_bit[got]));
          if (ser_motor !== exp_mot[got])
            chk(0, got == 0 ? "R9 first motor index" : "R5 motor index",
                int'(ser_motor), int'(exp_mot[got]));
        end
        got++;
      end
      if (done) begin
        seen_done = 1;
        chk(prev_vld == 1'b1, "R6 done follows final bit", int'(prev_vld), 1);
        chk(busy == 1'b0, "R6 busy low with done", busy, 0);
        chk(proto_err == exp_err, "R8 error flag", proto_err, int'(exp_err));
      end
      prev_vld = ser_vld;
    end
    start = 1'b0;
    chk(seen_done == 1'b1, "R6 done seen", int'(seen_done), 1);
    chk(got == exp_len, poke ? "R7 length with ignored start" : "R6 datagram length", got, exp_len);
    chk(first_c == 2, "R3 first bit timing", first_c, 2);
    chk(last_c - first_c + 1 == got, "R3 no gaps", last_c - first_c + 1, got);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(done == 1'b0 && ser_vld == 1'b0 && busy == 1'b0,
          poke ? "R7 no extra transfer" : "R6 single done", int'({done, ser_vld, busy}), 0);
      chk(proto_err == exp_err, "R8 error held", proto_err, int'(exp_err));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, ser_vld, done, proto_err} == 4'b0, "R1 in reset", int'({busy, ser_vld, done, proto_err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, ser_vld, done, proto_err} == 4'b0, "R1 after reset", int'({busy, ser_vld, done, proto_err}), 0);
    for (int s = 0; s < 4; s++) begin
      load_cfg(s, 0);
      for (int ld = 0; ld < 4; ld++) begin
        sig_bus = 32'h9E37_79B9 ^ (32'(s) * 32'h0101_0F0F) ^ (32'(ld) << 7);
        run_dgram(2'(ld), (s + ld) % 3 == 0);
      end
    end
    load_cfg(1, 1);
    for (int ld = 0; ld < 4; ld++) begin
      sig_bus = 32'hA5C3_3C5A ^ 32'(ld * 977);
      run_dgram(2'(ld), ld == 2);
    end
    load_cfg(2, 2);
    sig_bus = 32'h1234_ABCD;
    run_dgram(2'd1, 1'b0);
    run_dgram(2'd3, 1'b1);
    load_cfg(3, 0);
    sig_bus = 32'h0F0F_F0F0;
    run_dgram(2'd0, 1'b0);
    finish_run();
  end
endmodule